// File: doc/BRIEF.md
# Multiframe-Aligned Circular Transmit Buffer

This block is a byte store that sits between a control processor and a serial data link inserter. The processor loads bytes through a one-cycle write strobe. The serial side pulls the bytes out one bit at a time with a bit request strobe. A payload width select makes each stored byte carry either eight bits or only its six low bits.

The block has two modes, picked by a mode input. In FIFO mode it is an ordinary first-in first-out queue: bytes leave in the order they were written, and each byte leaves exactly once. In loop mode the processor builds a pattern of up to 64 bytes and closes it with an end-of-message strobe. The pattern stays parked until the serial side signals a multiframe boundary. From that boundary onward the pattern is sent from its first byte to its last and then starts again, with no end. The processor can build a replacement pattern while the current one keeps repeating. The replacement takes over at the first boundary after its own end-of-message, so the output stays aligned to the multiframe.

The multiframe pulse is sampled on the clock edge that comes before the multiframe's first bit. The bit request in that same cycle still receives the outgoing pattern's bit. The new pattern's first bit is offered in the next cycle.

Top module: `dl_circ_tx_buf`

## Requirements
- R1: After reset, tx_valid is 0, tx_bit is 1 and overflow is 0.
- R2: In FIFO mode (repeat_en=0), bytes go out in write order. Each byte is sent least significant bit first, one bit for each cycle with bit_req high. tx_valid is 1 exactly while at least one byte is stored.
- R3: A write is dropped, and the sticky overflow output is set until reset, in these cases: in FIFO mode when 64 bytes are stored; in loop mode when 64 bytes are already collected for the next pattern, or when a completed pattern is still waiting for its boundary.
- R4: When pack6=1, only bits 0 to 5 of each byte are sent, so a byte takes 6 bit requests. When pack6=0, all 8 bits are sent.
- R5: In loop mode, bytes that have been written do not reach tx_bit before an end-of-message strobe (eom) closes them into a pattern.
- R6: After an accepted eom, the pattern starts only in the cycle after a cycle with mf_start high. Its first bit is bit 0 of its first byte.
- R7: In loop mode, after the last bit of the last pattern byte, output wraps to bit 0 of the first byte, with no limit on the number of passes.
- R8: The running pattern keeps repeating unchanged while a new pattern is written and closed. It is replaced only at the next mf_start.
- R9: An eom strobe with no bytes collected since the last pattern was closed has no effect. The running pattern continues and no new pattern is armed.
- R10: A change of repeat_en empties the store, discards any pattern in progress or running, and restarts at bit 0. tx_valid is 0 afterwards. The overflow flag is kept.
- R11: mf_start is ignored when no closed pattern is waiting. eom is ignored in FIFO mode.
- R12: While tx_valid is 0, tx_bit is 1 and bit_req changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| repeat_en | input | 1 | 1 = loop mode, 0 = FIFO mode |
| pack6 | input | 1 | 1 = six payload bits per byte, 0 = eight |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| eom | input | 1 | End-of-message strobe (loop mode) |
| mf_start | input | 1 | Multiframe boundary pulse; the next bit begins a multiframe |
| bit_req | input | 1 | Serial side takes tx_bit this cycle |
| tx_bit | output | 1 | Current serial bit (1 when idle) |
| tx_valid | output | 1 | tx_bit carries stored data |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The checker watches four properties on every clock:
- tx_bit is 1 while idle;
- the overflow flag, once set, stays set;
- a change of mode always leaves the output idle;
- in loop mode, output starts only after a boundary pulse, and in FIFO mode the head bit holds while nothing is requested.

Other behaviour can only be shown by the bench, which compares against its queue model on every clock:
- the exact bit order and the wrap to the first byte;
- that a replacement pattern takes over at the right boundary while the old one keeps running;
- that an empty end-of-message is ignored;
- that writes are dropped at exactly 64 bytes.

// File: rtl/dlb_pkg.sv
// Shared types and helpers for the circular transmit buffer.
// Assumes the byte width is at least 6 bits.
package dlb_pkg;

    typedef enum logic {
        MODE_FIFO = 1'b0,
        MODE_LOOP = 1'b1
    } dlb_mode_e;

    localparam int unsigned PACK6_BITS = 6;

    // Index of the last payload bit of a byte for the selected packing.
    function automatic int unsigned last_bit_idx(input logic pack6, input int unsigned width);
        return pack6 ? (PACK6_BITS - 1) : (width - 1);
    endfunction

endpackage

// File: rtl/dlb_store.sv
// Two-bank byte storage with one write port and one combinational read port.
// Assumes the controller never reads a cell it has not written while the
// output is marked valid. The cells have no reset.
module dlb_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_fire,
    input  logic             wr_bank,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_bank,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WIDTH-1:0] cells [DEPTH];

        // Store the incoming byte when this bank is the write target.
        always_ff @(posedge clk) begin
            if (wr_fire && (wr_bank == 1'(b))) begin
                cells[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[b] = cells[rd_addr];
    end

    // Select the byte from the bank the reader is on.
    always_comb begin
        rd_data = bank_rd[rd_bank];
    end

endmodule

// File: rtl/dlb_bit_ser.sv
// Serialises the byte presented at its input, least significant bit first.
// It signals when the last payload bit of that byte is taken.
// Assumes pack6 is changed only while the output is idle.
module dlb_bit_ser
    import dlb_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned BW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pack6,
    input  logic [WIDTH-1:0] byte_in,
    input  logic             active,
    input  logic             bit_req,
    input  logic             restart,
    output logic             tx_bit,
    output logic             byte_done
);

    logic [BW-1:0] bit_idx_q;
    logic          at_last;

    // Flag the final payload bit of the current byte.
    always_comb begin
        at_last = (bit_idx_q == BW'(last_bit_idx(pack6, WIDTH)));
    end

    // Drive the current bit, idling high when there is nothing to send.
    always_comb begin
        tx_bit    = active ? byte_in[bit_idx_q] : 1'b1;
        byte_done = active && bit_req && at_last && !restart;
    end

    // Step through the byte on each request, restarting on command.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            bit_idx_q <= '0;
        end else if (active && bit_req) begin
            bit_idx_q <= at_last ? '0 : bit_idx_q + BW'(1);
        end
    end

endmodule

// File: rtl/dlb_ctrl.sv
// Write and read address control for both modes.
// FIFO mode: a ring in the active bank.
// Loop mode: a pattern is built in the idle bank. On the boundary pulse that
// follows its end-of-message, the banks swap and the pattern repeats without end.
// Assumes DEPTH is at least 2.
module dlb_ctrl
    import dlb_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          repeat_en,
    input  logic          wr_en,
    input  logic          eom,
    input  logic          mf_start,
    input  logic          byte_done,
    output logic          wr_fire,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          active,
    output logic          restart,
    output logic          overflow
);

    dlb_mode_e     mode_q;
    logic          act_q;
    logic [CW-1:0] act_len_q;
    logic [CW-1:0] wr_len_q;
    logic          pending_q;
    logic          running_q;
    logic [AW-1:0] rd_q;
    logic [AW-1:0] wp_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    logic flush, in_loop, in_fifo;
    logic swap, acc_loop, drop_loop, eom_ok;
    logic acc_fifo, drop_fifo;
    logic rd_wrap_loop, rd_wrap_fifo;

    // Decode what this cycle's strobes do in the current mode.
    always_comb begin
        flush        = (repeat_en != mode_q);
        in_loop      = (mode_q == MODE_LOOP) && !flush;
        in_fifo      = (mode_q == MODE_FIFO) && !flush;
        swap         = in_loop && pending_q && mf_start;
        acc_loop     = in_loop && wr_en && !pending_q && (wr_len_q != CW'(DEPTH));
        drop_loop    = in_loop && wr_en && !acc_loop;
        eom_ok       = in_loop && eom && !pending_q && (wr_len_q != '0);
        acc_fifo     = in_fifo && wr_en && (cnt_q != CW'(DEPTH));
        drop_fifo    = in_fifo && wr_en && (cnt_q == CW'(DEPTH));
        rd_wrap_loop = ({1'b0, rd_q} == (act_len_q - CW'(1)));
        rd_wrap_fifo = (rd_q == AW'(DEPTH - 1));
    end

    // Steer the storage ports and report the output state.
    always_comb begin
        wr_fire  = acc_loop || acc_fifo;
        wr_bank  = (mode_q == MODE_LOOP) ? ~act_q : act_q;
        wr_addr  = (mode_q == MODE_LOOP) ? wr_len_q[AW-1:0] : wp_q;
        rd_bank  = act_q;
        rd_addr  = rd_q;
        active   = (mode_q == MODE_LOOP) ? running_q : (cnt_q != '0);
        restart  = flush || swap;
        overflow = ovf_q;
    end

    // Track the mode; on a mode change, clear all pointers and lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= dlb_mode_e'(repeat_en);
        end else if (flush) begin
            mode_q <= dlb_mode_e'(repeat_en);
        end
    end

    // Loop mode: collect the next pattern, arm it, swap it in at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            act_q     <= 1'b0;
            act_len_q <= '0;
            wr_len_q  <= '0;
            pending_q <= 1'b0;
            running_q <= 1'b0;
        end else if (mode_q == MODE_LOOP) begin
            if (swap) begin
                act_q     <= ~act_q;
                act_len_q <= wr_len_q;
                wr_len_q  <= '0;
                pending_q <= 1'b0;
                running_q <= 1'b1;
            end else begin
                if (acc_loop) wr_len_q <= wr_len_q + CW'(1);
                if (eom_ok)   pending_q <= 1'b1;
            end
        end
    end

    // Read pointer: wraps at the pattern end in loop mode, at the ring end in FIFO mode.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || swap) begin
            rd_q <= '0;
        end else if (byte_done) begin
            if (mode_q == MODE_LOOP) begin
                rd_q <= rd_wrap_loop ? '0 : rd_q + AW'(1);
            end else begin
                rd_q <= rd_wrap_fifo ? '0 : rd_q + AW'(1);
            end
        end
    end

    // FIFO mode: write pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            cnt_q <= '0;
        end else if (mode_q == MODE_FIFO) begin
            if (acc_fifo) wp_q <= rd_wrap_fifo_w(wp_q);
            cnt_q <= cnt_q + CW'(acc_fifo) - CW'(byte_done);
        end
    end

    // Sticky flag for any dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (drop_loop || drop_fifo) begin
            ovf_q <= 1'b1;
        end
    end

    // Advance a ring pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] rd_wrap_fifo_w(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

endmodule

// File: rtl/dl_circ_tx_buf.sv
// Top of the circular transmit buffer: storage, address control and serialiser.
// Assumes bit_req, mf_start and the write strobes are synchronous to clk.
module dl_circ_tx_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             repeat_en,
    input  logic             pack6,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             eom,
    input  logic             mf_start,
    input  logic             bit_req,
    output logic             tx_bit,
    output logic             tx_valid,
    output logic             overflow
);

    logic             wr_fire, wr_bank, rd_bank;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [WIDTH-1:0] rd_data;
    logic             active, restart, byte_done;

    dlb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .repeat_en (repeat_en),
        .wr_en     (wr_en),
        .eom       (eom),
        .mf_start  (mf_start),
        .byte_done (byte_done),
        .wr_fire   (wr_fire),
        .wr_bank   (wr_bank),
        .wr_addr   (wr_addr),
        .rd_bank   (rd_bank),
        .rd_addr   (rd_addr),
        .active    (active),
        .restart   (restart),
        .overflow  (overflow)
    );

    dlb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .wr_fire (wr_fire),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dlb_bit_ser #(.WIDTH(WIDTH)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .pack6     (pack6),
        .byte_in   (rd_data),
        .active    (active),
        .bit_req   (bit_req),
        .restart   (restart),
        .tx_bit    (tx_bit),
        .byte_done (byte_done)
    );

    // Output is valid whenever the controller has data in play.
    always_comb begin
        tx_valid = active;
    end

endmodule

// File: rtl/dlb_checker.sv
// Port-level properties of the circular transmit buffer, attached by bind.
module dlb_checker (
    input logic clk,
    input logic rst_n,
    input logic repeat_en,
    input logic mf_start,
    input logic bit_req,
    input logic tx_bit,
    input logic tx_valid,
    input logic overflow
);

    // R1: the first cycle after reset is idle
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!tx_valid && !overflow));

    // R12: idle line is held high
    p_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> tx_bit);

    // R3: dropped-write flag is sticky
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10: a mode change leaves the output idle
    p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_en != $past(repeat_en)) |=> !tx_valid);

    // R6: loop output only begins after a boundary pulse
    p_start_on_mf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_en && $past(repeat_en) && $rose(tx_valid)) |-> $past(mf_start));

    // R2: FIFO head bit holds while nothing is requested
    p_hold_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!repeat_en && !$past(repeat_en) && tx_valid && !bit_req)
            |=> (tx_valid && $stable(tx_bit)));

endmodule

bind dl_circ_tx_buf dlb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .repeat_en (repeat_en),
    .mf_start  (mf_start),
    .bit_req   (bit_req),
    .tx_bit    (tx_bit),
    .tx_valid  (tx_valid),
    .overflow  (overflow)
);

// File: tb/tb_dl_circ_tx_buf.sv
// Queue-based reference model of the buffer, compared on every clock.
module tb_dl_circ_tx_buf;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       repeat_en = 1'b0, pack6 = 1'b0;
    logic       wr_en = 1'b0, eom = 1'b0, mf_start = 1'b0, bit_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_bit, tx_valid, overflow;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    // Reference model state
    logic [7:0] q[$];
    logic [7:0] pat[$];
    logic [7:0] nq[$];
    int         pos = 0, bp = 0;
    bit         pend = 0, run = 0, mmode = 0, ov = 0;

    dl_circ_tx_buf dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .repeat_en (repeat_en),
        .pack6     (pack6),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .eom       (eom),
        .mf_start  (mf_start),
        .bit_req   (bit_req),
        .tx_bit    (tx_bit),
        .tx_valid  (tx_valid),
        .overflow  (overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit exp_valid();
        return mmode ? run : (q.size() != 0);
    endfunction

    function automatic bit exp_bit();
        logic [7:0] b;
        if (!exp_valid()) return 1'b1;
        b = mmode ? pat[pos] : q[0];
        return b[bp];
    endfunction

    task automatic model_clear();
        q.delete(); pat.delete(); nq.delete();
        pos = 0; bp = 0; pend = 0; run = 0;
    endtask

    // Advance the model on each edge from the inputs alone.
    always @(posedge clk) begin
        int  last;
        bit  full, e_ok;
        last = pack6 ? 5 : 7;
        started = 1'b1;
        if (!rst_n) begin
            model_clear(); mmode = repeat_en; ov = 0;
        end else if (repeat_en != mmode) begin
            model_clear(); mmode = repeat_en;
        end else if (mmode) begin
            full = pend || (nq.size() == 64);
            e_ok = eom && !pend && (nq.size() != 0);
            if (mf_start && pend) begin
                pat = nq; nq.delete(); pend = 0; run = 1; pos = 0; bp = 0;
            end else if (bit_req && run) begin
                if (bp == last) begin bp = 0; pos = (pos + 1) % pat.size(); end
                else bp++;
            end
            if (wr_en) begin
                if (full) ov = 1; else nq.push_back(wr_data);
            end
            if (e_ok) pend = 1;
        end else begin
            full = (q.size() == 64);
            if (bit_req && q.size() != 0) begin
                if (bp == last) begin bp = 0; void'(q.pop_front()); end
                else bp++;
            end
            if (wr_en) begin
                if (full) ov = 1; else q.push_back(wr_data);
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            n_checks++;
            if (tx_valid !== exp_valid() || tx_bit !== exp_bit() || overflow !== ov) begin
                n_fail++;
                $display("FAIL %s t=%0t valid/bit/ovf got %0d/%0d/%0d exp %0d/%0d/%0d",
                         cur_req, $time, tx_valid, tx_bit, overflow,
                         exp_valid(), exp_bit(), ov);
            end
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
        wr_en = 0; eom = 0; mf_start = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask

    task automatic pulse_eom();
        eom = 1; cyc();
    endtask

    task automatic pulse_mf();
        mf_start = 1; cyc();
    endtask

    task automatic bits(input int n);
        bit_req = 1;
        for (int i = 0; i < n; i++) cyc();
        bit_req = 0;
    endtask

    task automatic expect1(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 0; cyc(); cyc(); cyc(); rst_n = 1; cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired got hang exp finish");
        report();
    end

    initial begin
        cur_req = "R1";
        do_reset();
        expect1("R1", tx_valid, 1'b0);
        expect1("R1", tx_bit, 1'b1);
        expect1("R1", overflow, 1'b0);

        // R2: FIFO order, LSB first
        cur_req = "R2";
        wr(8'hA5); wr(8'h3C); wr(8'hF0);
        expect1("R2", tx_valid, 1'b1);
        bits(24);
        expect1("R2", tx_valid, 1'b0);

        // R12: requests with nothing stored
        cur_req = "R12";
        bits(5);
        expect1("R12", tx_bit, 1'b1);

        // R11: eom and mf_start ignored in FIFO mode
        cur_req = "R11";
        wr(8'h96); pulse_eom(); pulse_mf();
        bits(3); pulse_mf(); bits(5);

        // R4: six-bit packing
        cur_req = "R4";
        pack6 = 1;
        wr(8'hC5); wr(8'h3F); wr(8'h81);
        bits(18);
        expect1("R4", tx_valid, 1'b0);
        pack6 = 0;

        // R3: FIFO full drops the 65th byte
        cur_req = "R3";
        for (int i = 0; i < 65; i++) wr(8'(i * 7 + 3));
        expect1("R3", overflow, 1'b1);
        bits(40);

        // R10: switch to loop mode flushes, flag kept
        cur_req = "R10";
        repeat_en = 1; cyc(); cyc();
        expect1("R10", tx_valid, 1'b0);
        expect1("R10", overflow, 1'b1);
        do_reset();
        repeat_en = 1; cyc(); cyc();

        // R5: bytes held before eom
        cur_req = "R5";
        wr(8'h11); wr(8'h22); wr(8'h83);
        bits(6);
        expect1("R5", tx_valid, 1'b0);

        // R6: armed pattern waits for the boundary
        cur_req = "R6";
        pulse_eom();
        bits(5);
        expect1("R6", tx_valid, 1'b0);
        bit_req = 1; pulse_mf();
        expect1("R6", tx_valid, 1'b1);
        expect1("R6", tx_bit, 1'b1);

        // R7: wrap over several passes
        cur_req = "R7";
        bits(24 * 3 + 5);

        // R9: empty eom changes nothing
        cur_req = "R9";
        pulse_eom(); bit_req = 1; pulse_mf(); bits(20);

        // R11: boundary pulse without an armed pattern does not realign
        cur_req = "R11";
        bits(3); bit_req = 1; pulse_mf(); bits(10);

        // R8: old pattern runs while the new one is built and armed
        cur_req = "R8";
        bit_req = 1;
        wr(8'h5A); wr(8'hE7);
        pulse_eom();
        bits(30);
        bit_req = 1; pulse_mf();
        bits(40);

        // R3: loop mode, 65th byte and writes while armed are dropped
        cur_req = "R3";
        do_reset();
        repeat_en = 1; pack6 = 1; cyc(); cyc();
        for (int i = 0; i < 64; i++) wr(8'(i * 13 + 1));
        expect1("R3", overflow, 1'b0);
        wr(8'hFF);
        expect1("R3", overflow, 1'b1);
        pulse_eom(); wr(8'h00); cyc();
        bit_req = 1; pulse_mf();
        bits(64 * 6 + 20);

        // R10: back to FIFO mode empties the store
        cur_req = "R10";
        repeat_en = 0; pack6 = 0; cyc(); cyc();
        expect1("R10", tx_valid, 1'b0);
        wr(8'h4D); bits(8);
        expect1("R10", tx_valid, 1'b0);

        cyc();
        report();
    end

endmodule